// File: doc/BRIEF.md
# Calibrated Real-Time Counter with Alarm

This block keeps wall-clock time as a 47-bit counter that advances on a slow tick enable, nominally 32768 Hz, sampled in the system clock domain. A signed 5-bit trim corrects oscillator drift. Within each calibration window of 2^WIN_LOG2 ticks, the first |trim| ticks advance the counter by two when the trim is positive and by zero when it is negative. Every full window therefore gains or loses exactly |trim| counts.

Two event sources feed sticky status flags. The first is a full-width alarm compare. The second is a periodic tap that fires when a selected counter bit rises. A single interrupt line is the OR of those flags, each gated by its own enable. Software reaches six 32-bit registers through a flat single-cycle port. Writes take effect at the next clock edge. Read data is combinational from the address.

Top module: `rtc_calib_top`

## Requirements
- R1: With run enabled (control bit 0) and calibration off, every cycle with `tick` high adds exactly 1 to the counter. Cycles without `tick`, and all cycles with run disabled, leave the counter unchanged.
- R2: The counter is 47 bits wide. Register 2 reads the upper 15 bits zero-extended, and register 3 reads the lower 32 bits. A write to register 2 keeps only its low 15 bits. Counting carries from the lower word into the upper word and wraps from all-ones to zero.
- R3: Writes to the counter registers (2, 3) are ignored while run is enabled.
- R4: With calibration enabled (control bit 8), control bits 14:10 hold a two's-complement trim c from -16 to +15. The window index counts ticks modulo 2^WIN_LOG2 and restarts at 0 when run is disabled. A tick whose window index is below |c| adds 2 when c > 0 and adds 0 when c < 0. Every other tick adds 1.
- R5: With calibration disabled, the trim field has no effect on counting.
- R6: Registers 4 and 5 hold the alarm in the same 15/32 split as the counter. While alarm enable (control bit 1) is 1, the alarm flag (status bit 0) is set on the edge after the counter equals the alarm. Alarm writes are ignored while alarm enable is 1.
- R7: Control bits 7:4 select counter bit n. A counting step that takes bit n from 0 to 1 sets the periodic flag (status bit 1) on that same edge. Counter writes never set it.
- R8: Status flags are sticky. Writing 1 to a bit of register 1 clears that bit, and writing 0 leaves it unchanged. An event in the same cycle as a clear wins.
- R9: `irq` is high exactly when (status bit 0 AND alarm enable) OR (status bit 1 AND periodic enable, control bit 3).
- R10: Register 0 is control and register 1 is status. Control reads back only bits 0, 1, 3-8 and 10-14, and all other bits read 0. After reset all registers and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle counting enable from the slow time base |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index 0-5 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Gated interrupt request |

## Verification
The in-RTL properties check the per-cycle invariants on every edge:
- the counter holds when no tick arrives or when run is off;
- without calibration a step is exactly one count;
- with calibration no step exceeds two counts;
- a frozen alarm stays stable;
- an alarm match always raises the alarm flag;
- an uncleared flag persists.

The long-range arithmetic needs the bench's scenarios. These cover the exact count gained or lost over whole and partial calibration windows for all 32 trim values, and the periodic flag first appearing at tick 2^n for each tap. They also cover carry across the word boundary and the interplay of W1C clearing with a persisting alarm match.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT   = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CNT_HI = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_CNT_LO = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_ALM_HI = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_ALM_LO = 3'd5;

  typedef struct packed {
    logic [4:0] trim;
    logic       trim_en;
    logic [3:0] tap_sel;
    logic       tap_en;
    logic       alm_en;
    logic       run_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [REG_DW-1:0] w);
    ctrl_t c;
    c.run_en  = w[0];
    c.alm_en  = w[1];
    c.tap_en  = w[3];
    c.tap_sel = w[7:4];
    c.trim_en = w[8];
    c.trim    = w[14:10];
    return c;
  endfunction

  function automatic logic [REG_DW-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_DW-1:0] w;
    w        = '0;
    w[0]     = c.run_en;
    w[1]     = c.alm_en;
    w[3]     = c.tap_en;
    w[7:4]   = c.tap_sel;
    w[8]     = c.trim_en;
    w[14:10] = c.trim;
    return w;
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step #(
  parameter int WIN_LOG2 = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       tick,
  input  logic       trim_en,
  input  logic [4:0] trim,
  output logic       step_en,
  output logic [1:0] step_amt
);

  logic [WIN_LOG2-1:0] win_q, win_d;
  logic [4:0]          mag;
  logic                in_adj;

  generate
    if (WIN_LOG2 < 5) begin : g_bad_win
      initial $error("WIN_LOG2 must be at least 5");
    end
  endgenerate

  always_comb begin
    mag     = trim[4] ? (~trim + 5'd1) : trim;
    in_adj  = trim_en && (win_q < WIN_LOG2'(mag));
    step_en = run_en && tick;
    if (!in_adj)       step_amt = 2'd1;
    else if (trim[4])  step_amt = 2'd0;
    else               step_amt = 2'd2;
    if (!run_en)       win_d = '0;
    else if (tick)     win_d = win_q + 1'b1;
    else               win_d = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (win_q == '0));

endmodule

// File: rtl/rtc_events.sv
module rtc_events #(
  parameter int CNT_W = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             step_en,
  input  logic [CNT_W-1:0] alarm,
  input  logic             alm_en,
  input  logic [3:0]       tap_sel,
  input  logic [1:0]       clr,
  output logic [1:0]       flags
);

  logic [1:0] flags_d;
  logic       alm_hit, tap_rise;

  always_comb begin
    alm_hit    = alm_en && (cnt_q == alarm);
    tap_rise   = step_en && !cnt_q[tap_sel] && cnt_d[tap_sel];
    flags_d[0] = alm_hit  | (flags[0] & ~clr[0]);
    flags_d[1] = tap_rise | (flags[1] & ~clr[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  // R6
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_en && cnt_q == alarm) |=> flags[0]);

  // R8
  sticky_alm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr[0]) |=> flags[0]);

  // R8
  sticky_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !clr[1]) |=> flags[1]);

  // R7
  tap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && (!flags[1] || clr[1])) |=> !flags[1]);

endmodule

// File: rtl/rtc_calib_top.sv
module rtc_calib_top
  import rtc_cal_pkg::*;
#(
  parameter int CNT_HI_W = 15,
  parameter int CNT_LO_W = 32,
  parameter int WIN_LOG2 = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);

  localparam int CNT_W = CNT_HI_W + CNT_LO_W;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, alm_q, alm_d;
  logic             step_en;
  logic [1:0]       step_amt;
  logic [1:0]       flags, clr;
  logic             wr_ctrl, wr_stat, wr_chi, wr_clo, wr_ahi, wr_alo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  rtc_cal_step #(.WIN_LOG2(WIN_LOG2)) u_step (
    .clk(clk), .rst_n(rst_sn), .run_en(ctrl_q.run_en), .tick(tick),
    .trim_en(ctrl_q.trim_en), .trim(ctrl_q.trim),
    .step_en(step_en), .step_amt(step_amt)
  );

  rtc_events #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_sn), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .step_en(step_en), .alarm(alm_q), .alm_en(ctrl_q.alm_en),
    .tap_sel(ctrl_q.tap_sel), .clr(clr), .flags(flags)
  );

  always_comb begin
    wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
    wr_stat = reg_wr && reg_addr == ADDR_STAT;
    wr_chi  = reg_wr && reg_addr == ADDR_CNT_HI && !ctrl_q.run_en;
    wr_clo  = reg_wr && reg_addr == ADDR_CNT_LO && !ctrl_q.run_en;
    wr_ahi  = reg_wr && reg_addr == ADDR_ALM_HI && !ctrl_q.alm_en;
    wr_alo  = reg_wr && reg_addr == ADDR_ALM_LO && !ctrl_q.alm_en;
    clr     = wr_stat ? reg_wdata[1:0] : 2'b00;

    ctrl_d = wr_ctrl ? ctrl_unpack(reg_wdata) : ctrl_q;

    cnt_d = cnt_q;
    if (step_en)     cnt_d = cnt_q + CNT_W'(step_amt);
    else if (wr_chi) cnt_d = {reg_wdata[CNT_HI_W-1:0], cnt_q[CNT_LO_W-1:0]};
    else if (wr_clo) cnt_d = {cnt_q[CNT_W-1:CNT_LO_W], reg_wdata[CNT_LO_W-1:0]};

    alm_d = alm_q;
    if (wr_ahi)      alm_d = {reg_wdata[CNT_HI_W-1:0], alm_q[CNT_LO_W-1:0]};
    else if (wr_alo) alm_d = {alm_q[CNT_W-1:CNT_LO_W], reg_wdata[CNT_LO_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      alm_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      alm_q  <= alm_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL:   reg_rdata = ctrl_pack(ctrl_q);
      ADDR_STAT:   reg_rdata = {30'd0, flags};
      ADDR_CNT_HI: reg_rdata = 32'(cnt_q[CNT_W-1:CNT_LO_W]);
      ADDR_CNT_LO: reg_rdata = cnt_q[CNT_LO_W-1:0];
      ADDR_ALM_HI: reg_rdata = 32'(alm_q[CNT_W-1:CNT_LO_W]);
      ADDR_ALM_LO: reg_rdata = alm_q[CNT_LO_W-1:0];
      default:     reg_rdata = '0;
    endcase
    irq = (flags[0] && ctrl_q.alm_en) || (flags[1] && ctrl_q.tap_en);
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_q.run_en && !tick) |=> $stable(cnt_q));

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ctrl_q.run_en && !(reg_wr && (reg_addr == ADDR_CNT_HI || reg_addr == ADDR_CNT_LO)))
    |=> $stable(cnt_q));

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_q.run_en && tick && !ctrl_q.trim_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_q.run_en && tick) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(2)));

  // R6
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl_q.alm_en |=> $stable(alm_q));

endmodule

// File: tb/tb_rtc_calib_top.sv
module tb_rtc_calib_top;

  localparam int WLOG = 6;
  localparam int WIN  = 1 << WLOG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  rtc_calib_top #(.WIN_LOG2(WLOG)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic rd_cnt(output logic [46:0] v);
    logic [31:0] h, l;
    rd(3'd2, h);
    rd(3'd3, l);
    v = {h[14:0], l};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [46:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd(3'd0, d); check("R10 ctrl reset", d, 0);
    rd(3'd1, d); check("R10 stat reset", d, 0);
    rd_cnt(c);   check("R10 cnt reset", c, 0);
    check("R10 irq reset", irq, 0);

    // R10 control field mask
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R10 ctrl mask", d, 32'h0000_7DFB);
    wr(3'd0, 0);
    wr(3'd1, 3);

    // R1 plain counting
    wr(3'd3, 32'h10);
    wr(3'd0, 32'h1);
    ticks(5);
    rd_cnt(c); check("R1 five ticks", c, 47'h15);
    repeat (10) @(negedge clk);
    rd_cnt(c); check("R1 hold without tick", c, 47'h15);
    // R3 counter write ignored while running
    wr(3'd3, 32'h999);
    rd_cnt(c); check("R3 write ignored", c, 47'h15);
    wr(3'd0, 0);
    ticks(3);
    rd_cnt(c); check("R1 stopped ignores tick", c, 47'h15);

    // R2 split and wrap
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R2 hi width", d, 32'h7FFF);
    wr(3'd3, 32'hFFFF_FFFE);
    wr(3'd0, 32'h1);
    ticks(1);
    rd_cnt(c); check("R2 all ones", c, {47{1'b1}});
    ticks(2);
    rd(3'd2, d); check("R2 wrap hi", d, 0);
    rd(3'd3, d); check("R2 wrap lo", d, 1);
    wr(3'd0, 0);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    ticks(1);
    rd(3'd2, d); check("R2 carry hi", d, 1);
    rd(3'd3, d); check("R2 carry lo", d, 0);

    // R4 trim sweep, all 32 codes
    for (int code = 0; code < 32; code++) begin
      int cv, mag, k, ex;
      cv  = (code >= 16) ? code - 32 : code;
      mag = (cv < 0) ? -cv : cv;
      wr(3'd0, 0);
      wr(3'd2, 0);
      wr(3'd3, 32'd1000);
      wr(3'd0, 32'h1 | 32'h100 | (code << 10));
      k = 0;
      for (int blk = 0; blk < 8; blk++) begin
        ticks(8);
        k += 8;
        ex = 1000 + k + ((cv < 0) ? -((k < mag) ? k : mag) : ((k < mag) ? k : mag));
        rd_cnt(c); check($sformatf("R4 trim %0d after %0d", cv, k), c, 47'(ex));
      end
      ticks(1);
      ex = 1000 + WIN + cv + 1 + ((mag > 0) ? ((cv < 0) ? -1 : 1) : 0);
      rd_cnt(c); check($sformatf("R4 trim %0d next window", cv), c, 47'(ex));
    end

    // R5 trim ignored when calibration off
    wr(3'd0, 0);
    wr(3'd3, 0);
    wr(3'd0, 32'h1 | (32'd16 << 10));
    ticks(WIN);
    rd_cnt(c); check("R5 trim off", c, 47'(WIN));

    // R6 alarm
    wr(3'd0, 0);
    wr(3'd1, 3);
    wr(3'd2, 1);
    wr(3'd3, 32'hFFFF_FFFE);
    wr(3'd4, 2);
    wr(3'd5, 1);
    wr(3'd0, 32'h3);
    ticks(2);
    rd(3'd1, d); check("R6 no early alarm", d[0], 0);
    check("R9 irq low before alarm", irq, 0);
    ticks(1);
    rd(3'd1, d); check("R6 alarm flag", d[0], 1);
    check("R9 irq alarm", irq, 1);
    wr(3'd5, 5);
    rd(3'd5, d); check("R6 alarm write ignored", d, 1);
    // R8 W1C behaviour
    wr(3'd1, 0);
    rd(3'd1, d); check("R8 write 0 keeps", d[0], 1);
    wr(3'd1, 1);
    rd(3'd1, d); check("R8 event beats clear", d[0], 1);
    ticks(1);
    wr(3'd1, 1);
    rd(3'd1, d); check("R8 clear", d[0], 0);
    check("R9 irq cleared", irq, 0);

    // R7 periodic tap sweep
    for (int n = 0; n < 6; n++) begin
      wr(3'd0, 0);
      wr(3'd1, 3);
      wr(3'd2, 0);
      wr(3'd3, 0);
      wr(3'd0, 32'h1 | 32'h8 | (n << 4));
      if (n > 0) ticks((1 << n) - 1);
      rd(3'd1, d); check($sformatf("R7 tap %0d quiet", n), d[1], 0);
      check($sformatf("R9 tap %0d irq low", n), irq, 0);
      ticks(1);
      rd(3'd1, d); check($sformatf("R7 tap %0d fires", n), d[1], 1);
      check($sformatf("R9 tap %0d irq", n), irq, 1);
    end

    // R9 gating by enable
    wr(3'd0, 0);
    wr(3'd1, 3);
    wr(3'd3, 0);
    wr(3'd0, 32'h1);
    ticks(1);
    rd(3'd1, d); check("R7 flag without enable", d[1], 1);
    check("R9 gated off", irq, 0);
    wr(3'd0, 32'h9);
    check("R9 gated on", irq, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule